// File: doc/BRIEF.md
# Reconfigurable Intra 4x4 Luma Predictor

This block produces the prediction samples for one 4x4 luma block in any of the nine 4x4 intra modes. A caller presents thirteen neighbouring reconstructed samples in one cycle: four from the column on the left, the corner sample above-left, four above and four above-right. Alongside them come three availability flags, a mode number and a one-cycle start strobe. The block captures these values and then emits the predicted block one row per cycle, four samples wide, over the next four cycles.

All modes share four identical processing elements, one per output column. Each cycle a tap selector sets every element to one of four operations: copy one neighbour, take the shared DC value, a two-tap average, or a three-tap smoothing filter. For the DC mode the elements are also chained. Each element adds its column's top and left neighbour to a running sum passed along from the element before it, and a final stage turns that sum into the DC value.

Top module: `intra4_pred`

## Requirements
- R1: While reset is held, and after it is released until the first accepted start, `valid_o` is low.
- R2: A start is accepted when `start_i` is high with `mode_i` in 0..8 at a rising edge while the block is idle. `valid_o` is then high for exactly the next four cycles, with `row_o` equal to 0, 1, 2, 3. After that it goes low unless a new start has been accepted.
- R3: A start raised while rows 0, 1 or 2 are being output is ignored. A start raised while row 3 is being output is accepted, and row 0 of the new block follows in the next cycle with no gap.
- R4: A start with `mode_i` in 9..15 is ignored and produces no output.
- R5: Mode 0 outputs the top neighbour of each column in every row. Mode 1 outputs the left neighbour of each row in every column.
- R6: Mode 2 outputs one value for all 16 samples. With both sides available it is (sum of four top and four left samples + 4) >> 3. With exactly one side available it is (sum of that side's four samples + 2) >> 2. With neither side available it is 128.
- R7: Modes 3 to 8 (diagonal down-left, diagonal down-right, vertical-right, horizontal-down, vertical-left, horizontal-up) follow the standard 4x4 luma directional equations. These use the three-tap form (a + 2b + c + 2) >> 2 and the two-tap form (a + b + 1) >> 1, with the corner standing in for index -1 on either side.
- R8: When `topright_avail_i` is low, all four above-right samples are replaced by the last top sample (top column 3).
- R9: Lane k of a vector port sits in bits [8k+7:8k]. In `left_i` lane k is the left sample of row k. In `top_i` lanes 0..3 are the top samples of columns 0..3 and lanes 4..7 are the above-right samples. In `pred_o` lane k is column k of the current row.
- R10: Neighbours, flags and mode are captured when a start is accepted. Input changes while a block is being output do not change its rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one block |
| mode_i | input | 4 | Prediction mode 0..8 |
| left_i | input | 32 | Left column samples, row 0 in lane 0 |
| corner_i | input | 8 | Above-left corner sample |
| top_i | input | 64 | Top row (lanes 0..3) and above-right (lanes 4..7) |
| left_avail_i | input | 1 | Left column is available |
| top_avail_i | input | 1 | Top row is available |
| topright_avail_i | input | 1 | Above-right samples are available |
| valid_o | output | 1 | A predicted row is on `pred_o` |
| row_o | output | 2 | Index of the row on `pred_o` |
| pred_o | output | 32 | Four predicted samples, column 0 in lane 0 |

## Verification
A wrong row counter or busy flag shows up at the ports within one cycle of the fault. It appears as a row index that skips or repeats, a fifth valid cycle, or a start that is wrongly ignored or taken. A tap selector that picks the wrong neighbour index for some (mode, column, row) corrupts exactly that lane in exactly that row. The scoreboard therefore covers every mode under several sample patterns, including all-maximum values, so that rounding and carry errors surface. A corrupted captured neighbour, or DC cascade sum, distorts every sample that depends on it throughout the four output cycles of that block.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
  localparam int BLK   = 4;
  localparam int ROW_W = $clog2(BLK);
  localparam int NEIGH = 3 * BLK + 1;
  localparam int IDX_W = $clog2(NEIGH);
  localparam int MODE_W = 4;
  localparam int MODE_MAX = 8;

  typedef enum logic [1:0] {OP_BYP, OP_DC, OP_TAP2, OP_TAP3} pe_op_e;

  typedef struct packed {
    pe_op_e           op;
    logic [IDX_W-1:0] ia;
    logic [IDX_W-1:0] ib;
    logic [IDX_W-1:0] ic;
  } tap_cfg_t;

  // Edge array index: 0..3 = left rows 3..0, 4 = corner, 5..12 = top cols 0..7
  function automatic tap_cfg_t tap_select(input logic [MODE_W-1:0] mode, input int x, input int y);
    tap_cfg_t cfg;
    pe_op_e   op;
    int a, b, c, z, n;
    op = OP_BYP; a = 4; b = 4; c = 4;
    case (mode)
      4'd0: b = 5 + x;
      4'd1: b = 3 - y;
      4'd2: op = OP_DC;
      4'd3: begin
        op = OP_TAP3;
        if (x == 3 && y == 3) begin a = 11; b = 12; c = 12; end
        else begin a = 5 + x + y; b = a + 1; c = a + 2; end
      end
      4'd4: begin
        op = OP_TAP3; a = 3 + x - y; b = a + 1; c = a + 2;
      end
      4'd5: begin
        z = 2 * x - y; n = x - (y >> 1);
        if (z < -1) begin op = OP_TAP3; a = 4 - y; b = a + 1; c = a + 2; end
        else if ((z & 1) == 0) begin op = OP_TAP2; a = 4 + n; b = 5 + n; end
        else begin op = OP_TAP3; a = 3 + n; b = 4 + n; c = 5 + n; end
      end
      4'd6: begin
        z = 2 * y - x; n = y - (x >> 1);
        if (z < -1) begin op = OP_TAP3; a = 2 + x; b = a + 1; c = a + 2; end
        else if ((z & 1) == 0) begin op = OP_TAP2; a = 3 - n; b = 4 - n; end
        else begin op = OP_TAP3; a = 3 - n; b = 4 - n; c = 5 - n; end
      end
      4'd7: begin
        n = x + (y >> 1);
        if ((y & 1) == 0) begin op = OP_TAP2; a = 5 + n; b = 6 + n; end
        else begin op = OP_TAP3; a = 5 + n; b = 6 + n; c = 7 + n; end
      end
      4'd8: begin
        z = x + 2 * y; n = y + (x >> 1);
        if (z > 5) begin op = OP_BYP; b = 0; end
        else if (z == 5) begin op = OP_TAP3; a = 1; b = 0; c = 0; end
        else if ((z & 1) == 0) begin op = OP_TAP2; a = 3 - n; b = 2 - n; end
        else begin op = OP_TAP3; a = 3 - n; b = 2 - n; c = 1 - n; end
      end
      default: ;
    endcase
    cfg.op = op;
    cfg.ia = IDX_W'(a);
    cfg.ib = IDX_W'(b);
    cfg.ic = IDX_W'(c);
    return cfg;
  endfunction
endpackage

// File: rtl/intra4_seq.sv
module intra4_seq
  import intra4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_ok_i,
  output logic             accept_o,
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o
);
  logic             busy_q;
  logic [ROW_W-1:0] row_q;
  logic             last_row;

  assign last_row = busy_q && (row_q == ROW_W'(BLK - 1));
  assign accept_o = start_i && mode_ok_i && (!busy_q || last_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      row_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      row_q  <= '0;
    end else if (busy_q) begin
      row_q <= row_q + 1'b1;
      if (last_row) busy_q <= 1'b0;
    end
  end

  assign valid_o = busy_q;
  assign row_o   = row_q;

  assert_row_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && row_o != ROW_W'(BLK - 1)) |=> (valid_o && row_o == $past(row_o) + 1'b1));
  assert_block_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && row_o == ROW_W'(BLK - 1) && !start_i) |=> !valid_o);
  assert_accept_row0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_ok_i && (!valid_o || row_o == ROW_W'(BLK - 1))) |=> (valid_o && row_o == '0));
  assert_bad_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mode_ok_i && !valid_o) |=> !valid_o);
endmodule

// File: rtl/intra4_pe.sv
module intra4_pe
  import intra4_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + 3
) (
  input  pe_op_e           op_i,
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic [PIX_W-1:0] c_i,
  input  logic [PIX_W-1:0] dc_i,
  input  logic [SUM_W-1:0] acc_i,
  input  logic [PIX_W-1:0] dc_top_i,
  input  logic [PIX_W-1:0] dc_left_i,
  output logic [SUM_W-1:0] acc_o,
  output logic [PIX_W-1:0] pred_o
);
  localparam int RAW_W = PIX_W + 2;
  localparam logic [RAW_W-1:0] PIX_MAX = RAW_W'((1 << PIX_W) - 1);

  logic [RAW_W-1:0] sum3, sum2, raw;

  // cascade stage of the DC accumulation
  assign acc_o = acc_i + SUM_W'(dc_top_i) + SUM_W'(dc_left_i);

  assign sum3 = RAW_W'(a_i) + (RAW_W'(b_i) << 1) + RAW_W'(c_i) + RAW_W'(2);
  assign sum2 = RAW_W'(a_i) + RAW_W'(b_i) + RAW_W'(1);

  always_comb begin
    unique case (op_i)
      OP_BYP:  raw = RAW_W'(b_i);
      OP_DC:   raw = RAW_W'(dc_i);
      OP_TAP2: raw = sum2 >> 1;
      default: raw = sum3 >> 2;
    endcase
  end

  assign pred_o = (raw > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : raw[PIX_W-1:0];
endmodule

// File: rtl/intra4_dc_norm.sv
module intra4_dc_norm #(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + 3
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic             left_avail_i,
  input  logic             top_avail_i,
  output logic [PIX_W-1:0] dc_o
);
  logic [SUM_W-1:0] both, one;

  assign both = (sum_i + SUM_W'(4)) >> 3;
  assign one  = (sum_i + SUM_W'(2)) >> 2;

  always_comb begin
    if (left_avail_i && top_avail_i)      dc_o = both[PIX_W-1:0];
    else if (left_avail_i || top_avail_i) dc_o = one[PIX_W-1:0];
    else                                  dc_o = PIX_W'(1 << (PIX_W - 1));
  end
endmodule

// File: rtl/intra4_pred.sv
module intra4_pred
  import intra4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic [BLK*PIX_W-1:0]    left_i,
  input  logic [PIX_W-1:0]        corner_i,
  input  logic [2*BLK*PIX_W-1:0]  top_i,
  input  logic                    left_avail_i,
  input  logic                    top_avail_i,
  input  logic                    topright_avail_i,
  output logic                    valid_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [BLK*PIX_W-1:0]    pred_o
);
  localparam int SUM_W = PIX_W + 3;
  localparam int NB_W  = NEIGH * PIX_W;
  localparam int TOP0  = BLK + 1;

  logic              accept;
  logic [NB_W-1:0]   nb_d, nb_q;
  logic [MODE_W-1:0] mode_q;
  logic              lav_q, tav_q;
  logic [PIX_W-1:0]  dc_val;
  logic [SUM_W-1:0]  acc [BLK+1];

  intra4_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_ok_i (mode_i <= MODE_W'(MODE_MAX)),
    .accept_o  (accept),
    .valid_o   (valid_o),
    .row_o     (row_o)
  );

  // Build edge array; missing above-right samples repeat the last top sample
  always_comb begin
    for (int i = 0; i < BLK; i++) begin
      nb_d[(BLK-1-i)*PIX_W +: PIX_W] = left_i[i*PIX_W +: PIX_W];
      nb_d[(TOP0+i)*PIX_W +: PIX_W]  = top_i[i*PIX_W +: PIX_W];
      nb_d[(TOP0+BLK+i)*PIX_W +: PIX_W] = topright_avail_i ? top_i[(BLK+i)*PIX_W +: PIX_W]
                                                           : top_i[(BLK-1)*PIX_W +: PIX_W];
    end
    nb_d[BLK*PIX_W +: PIX_W] = corner_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nb_q   <= '0;
      mode_q <= '0;
      lav_q  <= 1'b0;
      tav_q  <= 1'b0;
    end else if (accept) begin
      nb_q   <= nb_d;
      mode_q <= mode_i;
      lav_q  <= left_avail_i;
      tav_q  <= top_avail_i;
    end
  end

  assign acc[0] = '0;

  for (genvar k = 0; k < BLK; k++) begin : g_pe
    tap_cfg_t         cfg;
    logic [PIX_W-1:0] ta, tb, tc, dtop, dleft;

    always_comb begin
      cfg   = tap_select(mode_q, k, int'(row_o));
      ta    = nb_q[int'(cfg.ia)*PIX_W +: PIX_W];
      tb    = nb_q[int'(cfg.ib)*PIX_W +: PIX_W];
      tc    = nb_q[int'(cfg.ic)*PIX_W +: PIX_W];
      dtop  = tav_q ? nb_q[(TOP0+k)*PIX_W +: PIX_W] : '0;
      dleft = lav_q ? nb_q[(BLK-1-k)*PIX_W +: PIX_W] : '0;
    end

    intra4_pe #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_pe (
      .op_i      (cfg.op),
      .a_i       (ta),
      .b_i       (tb),
      .c_i       (tc),
      .dc_i      (dc_val),
      .acc_i     (acc[k]),
      .dc_top_i  (dtop),
      .dc_left_i (dleft),
      .acc_o     (acc[k+1]),
      .pred_o    (pred_o[k*PIX_W +: PIX_W])
    );

    if (k > 0) begin : g_dc_chk
      assert_dc_flat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && mode_q == MODE_W'(2)) |-> (pred_o[k*PIX_W +: PIX_W] == pred_o[PIX_W-1:0]));
    end

    assert_horz_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && mode_q == MODE_W'(1)) |->
        (pred_o[k*PIX_W +: PIX_W] == nb_q[(BLK-1-int'(row_o))*PIX_W +: PIX_W]));
  end

  intra4_dc_norm #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_dc (
    .sum_i        (acc[BLK]),
    .left_avail_i (lav_q),
    .top_avail_i  (tav_q),
    .dc_o         (dc_val)
  );

  assert_vert_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == MODE_W'(0)) |-> (pred_o == nb_q[TOP0*PIX_W +: BLK*PIX_W]));
  assert_capture_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept) |=> ($stable(nb_q) && $stable(mode_q)));
endmodule

// File: tb/intra4_pred_tb_top.sv
module intra4_pred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] left = '0;
  logic [7:0]  corner = '0;
  logic [63:0] top = '0;
  logic        lav = 1'b0, tav = 1'b0, trav = 1'b0;
  logic        valid;
  logic [1:0]  row;
  logic [31:0] pred;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic [1:0]  q_row[$];
  logic [31:0] q_pred[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  intra4_pred dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .left_i(left), .corner_i(corner), .top_i(top),
    .left_avail_i(lav), .top_avail_i(tav), .topright_avail_i(trav),
    .valid_o(valid), .row_o(row), .pred_o(pred)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  function automatic int tp(logic [7:0] c, logic [63:0] t, int k);
    return (k < 0) ? int'(c) : int'(t[k*8 +: 8]);
  endfunction

  function automatic int lp(logic [7:0] c, logic [31:0] l, int k);
    return (k < 0) ? int'(c) : int'(l[k*8 +: 8]);
  endfunction

  function automatic int f3(int a, int b, int c);
    return (a + 2 * b + c + 2) >> 2;
  endfunction

  function automatic int f2(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic logic [7:0] ref_px(int md, int x, int y, logic [31:0] l, logic [7:0] c,
                                        logic [63:0] t, bit la, bit ta);
    int z, s;
    case (md)
      0: return 8'(tp(c, t, x));
      1: return 8'(lp(c, l, y));
      2: begin
        s = 0;
        for (int i = 0; i < 4; i++) s += (la ? lp(c, l, i) : 0) + (ta ? tp(c, t, i) : 0);
        if (la && ta) return 8'((s + 4) >> 3);
        if (la || ta) return 8'((s + 2) >> 2);
        return 8'd128;
      end
      3: if (x == 3 && y == 3) return 8'((tp(c, t, 6) + 3 * tp(c, t, 7) + 2) >> 2);
         else return 8'(f3(tp(c, t, x + y), tp(c, t, x + y + 1), tp(c, t, x + y + 2)));
      4: if (x > y) return 8'(f3(tp(c, t, x - y - 2), tp(c, t, x - y - 1), tp(c, t, x - y)));
         else if (x < y) return 8'(f3(lp(c, l, y - x - 2), lp(c, l, y - x - 1), lp(c, l, y - x)));
         else return 8'(f3(tp(c, t, 0), int'(c), lp(c, l, 0)));
      5: begin
        z = 2 * x - y;
        if (z >= 0 && z % 2 == 0) return 8'(f2(tp(c, t, x - (y >> 1) - 1), tp(c, t, x - (y >> 1))));
        if (z > 0) return 8'(f3(tp(c, t, x - (y >> 1) - 2), tp(c, t, x - (y >> 1) - 1), tp(c, t, x - (y >> 1))));
        if (z == -1) return 8'(f3(lp(c, l, 0), int'(c), tp(c, t, 0)));
        return 8'(f3(lp(c, l, y - 1), lp(c, l, y - 2), lp(c, l, y - 3)));
      end
      6: begin
        z = 2 * y - x;
        if (z >= 0 && z % 2 == 0) return 8'(f2(lp(c, l, y - (x >> 1) - 1), lp(c, l, y - (x >> 1))));
        if (z > 0) return 8'(f3(lp(c, l, y - (x >> 1) - 2), lp(c, l, y - (x >> 1) - 1), lp(c, l, y - (x >> 1))));
        if (z == -1) return 8'(f3(lp(c, l, 0), int'(c), tp(c, t, 0)));
        return 8'(f3(tp(c, t, x - 1), tp(c, t, x - 2), tp(c, t, x - 3)));
      end
      7: if (y % 2 == 0) return 8'(f2(tp(c, t, x + (y >> 1)), tp(c, t, x + (y >> 1) + 1)));
         else return 8'(f3(tp(c, t, x + (y >> 1)), tp(c, t, x + (y >> 1) + 1), tp(c, t, x + (y >> 1) + 2)));
      default: begin
        z = x + 2 * y;
        if (z > 5) return 8'(lp(c, l, 3));
        if (z == 5) return 8'((lp(c, l, 2) + 3 * lp(c, l, 3) + 2) >> 2);
        if (z % 2 == 0) return 8'(f2(lp(c, l, y + (x >> 1)), lp(c, l, y + (x >> 1) + 1)));
        return 8'(f3(lp(c, l, y + (x >> 1)), lp(c, l, y + (x >> 1) + 1), lp(c, l, y + (x >> 1) + 2)));
      end
    endcase
  endfunction

  // Driver: raise start for one cycle and push the four expected rows
  task automatic drive_block(input int md, input bit la, input bit ta, input bit tra,
                             input logic [31:0] l, input logic [7:0] c, input logic [63:0] t,
                             input string tag);
    logic [63:0] te;
    logic [31:0] r;
    @(negedge clk);
    start = 1'b1; mode = 4'(md); left = l; corner = c; top = t;
    lav = la; tav = ta; trav = tra;
    te = t;
    if (!tra) for (int k = 4; k < 8; k++) te[k*8 +: 8] = t[31:24];
    for (int y = 0; y < 4; y++) begin
      for (int x = 0; x < 4; x++) r[x*8 +: 8] = ref_px(md, x, y, l, c, te, la, ta);
      q_row.push_back(2'(y));
      q_pred.push_back(r);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic rand_block(input int md, input bit la, input bit ta, input bit tra, input string tag);
    logic [31:0] l;
    logic [63:0] t;
    logic [7:0]  c;
    for (int i = 0; i < 4; i++) l[i*8 +: 8] = rnd();
    for (int i = 0; i < 8; i++) t[i*8 +: 8] = rnd();
    c = rnd();
    drive_block(md, la, ta, tra, l, c, t, tag);
  endtask

  // Monitor: compare each valid row against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q_row.size() == 0) begin
        check(1'b0, "R2 unexpected row", {30'd0, row, pred}, 64'd0);
      end else begin
        automatic logic [1:0]  er = q_row.pop_front();
        automatic logic [31:0] ep = q_pred.pop_front();
        automatic string       et = q_tag.pop_front();
        check({row, pred} == {er, ep}, et, {30'd0, row, pred}, {30'd0, er, ep});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", 64'(valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R1 valid after reset", 64'(valid), 64'd0);

    // R9 lane packing with a ramp, vertical and horizontal
    drive_block(0, 1, 1, 1, 32'h40_30_20_10, 8'h05, 64'h88_77_66_55_44_33_22_11, "R9 R5 vertical ramp");
    repeat (4) @(negedge clk);
    check(valid == 1'b0, "R2 valid after four rows", 64'(valid), 64'd0);
    drive_block(1, 1, 1, 1, 32'h40_30_20_10, 8'h05, 64'h88_77_66_55_44_33_22_11, "R9 R5 horizontal ramp");
    repeat (4) @(negedge clk);

    // every mode under random and all-maximum patterns
    for (int md = 0; md < 9; md++) begin
      for (int p = 0; p < 3; p++) begin
        rand_block(md, 1, 1, 1, (md < 2) ? "R5 random" : (md == 2) ? "R6 random" : "R7 random");
        repeat (4) @(negedge clk);
      end
      drive_block(md, 1, 1, 1, '1, 8'hff, '1, (md == 2) ? "R6 max" : "R7 max");
      repeat (4) @(negedge clk);
    end

    // DC availability cases
    rand_block(2, 1, 0, 1, "R6 left only");
    repeat (4) @(negedge clk);
    rand_block(2, 0, 1, 1, "R6 top only");
    repeat (4) @(negedge clk);
    rand_block(2, 0, 0, 1, "R6 none");
    repeat (4) @(negedge clk);

    // missing above-right samples
    rand_block(3, 1, 1, 0, "R8 down-left no top-right");
    repeat (4) @(negedge clk);
    rand_block(7, 1, 1, 0, "R8 vertical-left no top-right");
    repeat (4) @(negedge clk);

    // start during row 1 ignored, inputs changed mid-block, start during row 3 taken
    rand_block(4, 1, 1, 1, "R3 R10 first block");
    @(negedge clk);
    start = 1'b1; mode = 4'd1; left = 32'hdead_beef; corner = 8'h00; top = '0;
    @(negedge clk);
    start = 1'b0;
    rand_block(6, 1, 1, 1, "R3 back-to-back");
    repeat (4) @(negedge clk);
    check(valid == 1'b0, "R3 valid after back-to-back", 64'(valid), 64'd0);

    // out-of-range modes ignored
    @(negedge clk);
    start = 1'b1; mode = 4'd9;
    @(negedge clk);
    check(valid == 1'b0, "R4 mode 9 ignored", 64'(valid), 64'd0);
    mode = 4'd15;
    @(negedge clk);
    check(valid == 1'b0, "R4 mode 15 ignored", 64'(valid), 64'd0);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(valid == 1'b0, "R4 no late output", 64'(valid), 64'd0);

    repeat (4) @(negedge clk);
    check(q_row.size() == 0, "R2 rows outstanding", 64'(q_row.size()), 64'd0);
    finish_run();
  end
endmodule